// File: doc/BRIEF.md
# Global Timer Register Bank

This block holds a set of down-counting global timers behind a 32-bit register port, together with one timer frequency register per processor. Software programs a base count for each timer. While the timer's inhibit bit (bit 31 of the base count) is clear, every tick pulse moves the timer one step. When a period ends, the timer reloads from the base, flips the toggle bit (bit 31 of the current count) and raises a one-cycle interrupt request. Each timer also stores a vector/priority word and a destination word for the interrupt controller around it. The block only stores these two words; it does not interpret them.

The register offset carries all of the addressing. Offset bits [7:6] pick the timer and bits [5:4] pick the register within it. Bits [15:12] pick the processor for the frequency register. Bits [11:8] are not decoded, so they alias. The frequency register sits in the destination slot at every offset whose bits [7:4] are all ones. An access whose low four offset bits are not zero is dropped. Tick generation and prescaling happen outside the block; the block only sees the tick enable.

Top module: `gtmr_bank`

## Requirements
- R1: After reset, each current count reads 0x00000000, each base count 0x80000000, each vector/priority word 0x80800000, each destination word 0x00000001, each frequency register 0, and no interrupt request is high.
- R2: For an aligned offset, bits [7:6] give the timer index and bits [5:4] give the register: 00 current count, 01 base count, 10 vector/priority, 11 destination. Bits [11:8] are ignored. Writes to base, vector/priority and destination store the full 32-bit word, and it reads back unchanged.
- R3: A slot-11 access whose offset bits [7:4] equal 0xF targets the frequency register of processor offset[15:12] and leaves every timer destination untouched. For a processor index at or above NUM_CPUS, the write is dropped and the read returns 0.
- R4: An access with any of offset bits [3:0] set changes no register, and a read of it returns 0xFFFFFFFF.
- R5: A write to a current-count register has no effect on it.
- R6: A base write always stores the new value. It clears current-count bit 31 only when that bit is set, the old base bit 31 is set, and the new value's bit 31 is clear. In every other case, current-count bit 31 keeps its value.
- R7: While base bit 31 is set, ticks do not change the current count.
- R8: A base write with bit 31 clear leaves the current count's low 31 bits alone until the next tick. That tick copies the base's low 31 bits into them, leaves bit 31 as it is, and raises no interrupt.
- R9: Once loaded and not inhibited, a tick does one of two things. If the low 31 bits exceed 1, it decrements them. If they are 1 or 0, it reloads them from the base, inverts bit 31, and drives that timer's interrupt request high for the following cycle. A base of N≥1 therefore gives one request every N ticks.
- R10: With tick_en low, no current count changes except through R6. In a cycle where a timer's base is written, the tick is not applied to that timer.
- R11: An interrupt request is high only in the cycle after the tick that ended the period. Requests of different timers are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 16 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tick_en | input | 1 | Count-step enable, one pulse per tick |
| timer_irq | output | NUM_TIMERS | One-cycle interrupt request per timer |

## Verification
Some properties are checked on every cycle. A timer holds its count while inhibited or while no tick arrives. A base write masks the tick for that timer. Every interrupt request follows a tick and coincides with a flip of the toggle bit. A misaligned access never produces a write enable. Other behaviour needs the bench's directed scenarios: the address decode with its aliasing and the frequency-register shadowing, the exact conditions of the bit-31 clearing rule, the deferred load on the first tick, and the length of a period from base to request.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
   localparam int DATA_W = 32;
   localparam int OFFS_W = 16;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'b00,
      SEL_BASE   = 2'b01,
      SEL_VECPRI = 2'b10,
      SEL_DEST   = 2'b11
   } gtmr_sel_e;

   typedef struct packed {
      logic       aligned;
      logic [1:0] tidx;
      gtmr_sel_e  sel;
      logic       freq_hit;
      logic [3:0] cpu;
   } gtmr_dec_t;
endpackage

// File: rtl/gtmr_decode.sv
module gtmr_decode
   import gtmr_pkg::*;
(
   input  logic [OFFS_W-1:0] offs,
   output gtmr_dec_t         dec
);
   // bits [11:8] take no part in the decode and alias
   logic [3:0] unused_mid;
   assign unused_mid   = offs[11:8];

   assign dec.aligned  = (offs[3:0] == 4'h0);
   assign dec.tidx     = offs[7:6];
   assign dec.sel      = gtmr_sel_e'(offs[5:4]);
   assign dec.freq_hit = (offs[7:4] == 4'hF);
   assign dec.cpu      = offs[15:12];
endmodule

// File: rtl/gtmr_channel.sv
module gtmr_channel
   import gtmr_pkg::*;
#(
   parameter logic [DATA_W-1:0] BASE_RST = 32'h8000_0000,
   parameter logic [DATA_W-1:0] VEC_RST  = 32'h8080_0000,
   parameter logic [DATA_W-1:0] DEST_RST = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              base_we,
   input  logic              vec_we,
   input  logic              dest_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] count_q,
   output logic [DATA_W-1:0] base_q,
   output logic [DATA_W-1:0] vec_q,
   output logic [DATA_W-1:0] dest_q,
   output logic              irq_q
);
   localparam int MSB = DATA_W - 1;

   logic pend_q;   // base written with inhibit clear, load on next tick
   logic period_end;
   assign period_end = (count_q[MSB-1:0] <= (MSB)'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         base_q  <= BASE_RST;
         vec_q   <= VEC_RST;
         dest_q  <= DEST_RST;
         pend_q  <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (base_we) begin
            base_q <= wdata;
            pend_q <= ~wdata[MSB];
            if (count_q[MSB] && base_q[MSB] && !wdata[MSB])
               count_q[MSB] <= 1'b0;
         end else if (tick && !base_q[MSB]) begin
            if (pend_q) begin
               count_q[MSB-1:0] <= base_q[MSB-1:0];
               pend_q           <= 1'b0;
            end else if (period_end) begin
               count_q <= {~count_q[MSB], base_q[MSB-1:0]};
               irq_q   <= 1'b1;
            end else begin
               count_q[MSB-1:0] <= count_q[MSB-1:0] - (MSB)'(1);
            end
         end
         if (vec_we)  vec_q  <= wdata;
         if (dest_we) dest_q <= wdata;
      end
   end

   assert_inhibit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (base_q[MSB] && !base_we) |=> $stable(count_q));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !base_we) |=> $stable(count_q));

   assert_write_masks_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      base_we |=> (count_q[MSB-1:0] == $past(count_q[MSB-1:0])));

   assert_irq_after_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(tick));

   assert_irq_toggles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> (count_q[MSB] != $past(count_q[MSB])));
endmodule

// File: rtl/gtmr_freq_bank.sv
module gtmr_freq_bank
   import gtmr_pkg::*;
#(
   parameter int NUM_CPUS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [3:0]        cpu,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd
);
   logic [DATA_W-1:0] freq_q [NUM_CPUS];

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      always_ff @(posedge clk) begin
         if (!rst_n)                     freq_q[c] <= '0;
         else if (we && cpu == 4'(c))    freq_q[c] <= wdata;
      end
   end

   always_comb begin
      rd = '0;
      for (int c = 0; c < NUM_CPUS; c++)
         if (cpu == 4'(c)) rd = freq_q[c];
   end
endmodule

// File: rtl/gtmr_bank.sv
module gtmr_bank
   import gtmr_pkg::*;
#(
   parameter int                NUM_TIMERS = 4,
   parameter int                NUM_CPUS   = 2,
   parameter logic [DATA_W-1:0] BASE_RST   = 32'h8000_0000,
   parameter logic [DATA_W-1:0] VEC_RST    = 32'h8080_0000,
   parameter logic [DATA_W-1:0] DEST_RST   = 32'h0000_0001
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [OFFS_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  tick_en,
   output logic [NUM_TIMERS-1:0] timer_irq
);
   if (NUM_TIMERS < 1 || NUM_TIMERS > 4) begin : g_bad_timers
      $error("gtmr_bank: NUM_TIMERS must lie in 1..4");
   end
   if (NUM_CPUS < 1 || NUM_CPUS > 16) begin : g_bad_cpus
      $error("gtmr_bank: NUM_CPUS must lie in 1..16");
   end

   gtmr_dec_t dec;
   gtmr_decode u_dec (.offs(reg_addr), .dec(dec));

   logic                  hit;
   logic [NUM_TIMERS-1:0] base_we, vec_we, dest_we;
   logic                  freq_we;
   logic [DATA_W-1:0]     freq_rd;
   logic [DATA_W-1:0]     cnt_a  [NUM_TIMERS];
   logic [DATA_W-1:0]     base_a [NUM_TIMERS];
   logic [DATA_W-1:0]     vec_a  [NUM_TIMERS];
   logic [DATA_W-1:0]     dest_a [NUM_TIMERS];

   assign hit     = reg_wr && dec.aligned;
   assign freq_we = hit && dec.sel == SEL_DEST && dec.freq_hit;

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      logic sel_t;
      assign sel_t      = hit && dec.tidx == 2'(t);
      assign base_we[t] = sel_t && dec.sel == SEL_BASE;
      assign vec_we[t]  = sel_t && dec.sel == SEL_VECPRI;
      assign dest_we[t] = sel_t && dec.sel == SEL_DEST && !dec.freq_hit;

      gtmr_channel #(
         .BASE_RST(BASE_RST), .VEC_RST(VEC_RST), .DEST_RST(DEST_RST)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick_en),
         .base_we(base_we[t]), .vec_we(vec_we[t]), .dest_we(dest_we[t]),
         .wdata(reg_wdata),
         .count_q(cnt_a[t]), .base_q(base_a[t]), .vec_q(vec_a[t]),
         .dest_q(dest_a[t]), .irq_q(timer_irq[t])
      );
   end

   gtmr_freq_bank #(.NUM_CPUS(NUM_CPUS)) u_freq (
      .clk(clk), .rst_n(rst_n), .we(freq_we), .cpu(dec.cpu),
      .wdata(reg_wdata), .rd(freq_rd)
   );

   always_comb begin
      reg_rdata = '0;
      if (!dec.aligned) begin
         reg_rdata = '1;
      end else if (dec.sel == SEL_DEST && dec.freq_hit) begin
         reg_rdata = freq_rd;
      end else begin
         for (int t = 0; t < NUM_TIMERS; t++) begin
            if (dec.tidx == 2'(t)) begin
               case (dec.sel)
                  SEL_COUNT:  reg_rdata = cnt_a[t];
                  SEL_BASE:   reg_rdata = base_a[t];
                  SEL_VECPRI: reg_rdata = vec_a[t];
                  default:    reg_rdata = dest_a[t];
               endcase
            end
         end
      end
   end

   assert_misaligned_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[3:0] != 4'h0) |->
         (base_we == '0 && vec_we == '0 && dest_we == '0 && !freq_we));

   assert_freq_shadows_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr[7:0] == 8'hF0) |-> (dest_we == '0));
endmodule

// File: tb/gtmr_bank_test.sv
module gtmr_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr = 0;
   logic [15:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        tick_en = 0;
   logic [NT-1:0] timer_irq;

   int n_checks = 0;
   int n_fail   = 0;

   gtmr_bank #(.NUM_TIMERS(NT), .NUM_CPUS(2)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
      .timer_irq(timer_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick_en = 1;
         @(negedge clk);
         tick_en = 0;
      end
      #1;
   endtask

   task automatic t_reset;
      for (int t = 0; t < NT; t++) begin
         rd_chk("R1 count", 16'(t*64 + 'h00), 32'h0);
         rd_chk("R1 base",  16'(t*64 + 'h10), 32'h8000_0000);
         rd_chk("R1 vec",   16'(t*64 + 'h20), 32'h8080_0000);
      end
      rd_chk("R1 dest0", 16'h0030, 32'h1);
      rd_chk("R1 freq0", 16'h00F0, 32'h0);
      check("R1 irq", 32'(timer_irq), 32'h0);
   endtask

   task automatic t_decode;
      wr(16'h00A0, 32'hDEAD_BEEF);
      rd_chk("R2 vec2", 16'h00A0, 32'hDEAD_BEEF);
      wr(16'h0E60, 32'h1234_5678);              // alias bits [11:8]
      rd_chk("R2 alias vec1", 16'h0060, 32'h1234_5678);
      wr(16'h0070, 32'hA5A5_0F0F);
      rd_chk("R2 dest1", 16'h0070, 32'hA5A5_0F0F);
      rd_chk("R2 dest0 untouched", 16'h0030, 32'h1);
      wr(16'h10F0, 32'h0BEB_C200);
      rd_chk("R3 freq1", 16'h10F0, 32'h0BEB_C200);
      rd_chk("R3 freq0 untouched", 16'h00F0, 32'h0);
      rd_chk("R3 dest2 untouched", 16'h00B0, 32'h1);
      wr(16'h20F0, 32'hFFFF_0000);
      rd_chk("R3 cpu out of range", 16'h20F0, 32'h0);
   endtask

   task automatic t_misaligned;
      wr(16'h0014, 32'h0000_0003);
      rd_chk("R4 base0 untouched", 16'h0010, 32'h8000_0000);
      rd_chk("R4 misaligned read", 16'h0014, 32'hFFFF_FFFF);
      wr(16'h0000, 32'h0000_1234);
      rd_chk("R5 count ignores write", 16'h0000, 32'h0);
   endtask

   task automatic t_count;
      tick(3);
      rd_chk("R7 inhibited hold", 16'h0000, 32'h0);
      wr(16'h0010, 32'h0000_0005);
      rd_chk("R8 no load before tick", 16'h0000, 32'h0);
      tick(1);
      check("R8 no irq on load", 32'(timer_irq), 32'h0);
      rd_chk("R8 load on tick", 16'h0000, 32'h5);
      tick(4);
      rd_chk("R9 decrement", 16'h0000, 32'h1);
      tick(1);
      check("R9 irq0 pulse", 32'(timer_irq), 32'h1);
      rd_chk("R9 reload toggle", 16'h0000, 32'h8000_0005);
      #1;
      check("R11 irq one cycle", 32'(timer_irq), 32'h0);
   endtask

   task automatic t_inhibit;
      wr(16'h0010, 32'h8000_0003);
      rd_chk("R6 old base clear keeps bit31", 16'h0000, 32'h8000_0005);
      tick(2);
      rd_chk("R7 hold after inhibit", 16'h0000, 32'h8000_0005);
      wr(16'h0010, 32'h0000_0007);
      rd_chk("R6 bit31 cleared", 16'h0000, 32'h0000_0005);
      rd_chk("R6 base stored", 16'h0010, 32'h0000_0007);
      tick(1);
      rd_chk("R8 reload after uninhibit", 16'h0000, 32'h0000_0007);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      reg_wr = 1; reg_addr = 16'h0050; reg_wdata = 32'h3; tick_en = 1;
      @(negedge clk);
      reg_wr = 0; tick_en = 0;
      rd_chk("R10 write masks tick", 16'h0040, 32'h0);
      rd_chk("R10 other timer ticks", 16'h0000, 32'h6);
      repeat (3) @(negedge clk);
      rd_chk("R10 idle hold", 16'h0000, 32'h6);
      tick(1);
      rd_chk("R8 timer1 load", 16'h0040, 32'h3);
      rd_chk("R9 timer0 step", 16'h0000, 32'h5);
   endtask

   task automatic t_zero_base;
      wr(16'h0090, 32'h0);
      tick(1);
      rd_chk("R8 timer2 load zero", 16'h0080, 32'h0);
      tick(1);
      check("R11 irq2 only timer2", 32'(timer_irq[2]), 32'h1);
      check("R11 irq0 quiet", 32'(timer_irq[0]), 32'h0);
      rd_chk("R9 zero base toggle", 16'h0080, 32'h8000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_decode();
      t_misaligned();
      t_count();
      t_inhibit();
      t_same_cycle();
      t_zero_base();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule